// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps three 256-bit vector sets for a single processor: the requests waiting to be taken, the vectors currently being serviced, and a per-vector trigger-mode flag. It compares the best waiting request against a processor priority and raises a registered interrupt-request line when that request is more urgent. The processor priority is built from the task-priority register and the class of the most urgent in-service vector.

The processor takes an interrupt with a one-cycle acknowledge strobe. The block replies with the chosen vector, or with the spurious vector when the request does not clear the task priority. An end-of-interrupt strobe retires the most urgent in-service vector. Software writes the task priority and the spurious/enable register through dedicated write ports. The three vector sets and the processor priority are visible on read ports.

Top module: `vipc_top`

## Requirements
- R1: Among set bits of any vector set, the larger vector number ranks higher; acknowledge takes the largest pending vector.
- R2: `ppr_o` equals the task priority when its bits 7:4 are at least bits 7:4 of the largest in-service vector (0 when none is in service), and otherwise equals that in-service class with bits 3:0 zero.
- R3: `irq_o` can be 1 only when bit 8 (enable) of the spurious register and at least one pending bit were set in the cycle before.
- R4: With the block enabled and a request pending, `irq_o` stays 0 if `ppr_o` is nonzero and the pending class (vector bits 7:4) is at or below the class in `ppr_o` bits 7:4. Otherwise it goes to 1.
- R5: An enabled acknowledge with a request pending clears that pending bit. If the task priority is nonzero and the vector is at or below it, `ack_vec_o` is spurious bits 7:0 and no in-service bit is set. Otherwise the in-service bit is set and `ack_vec_o` is the vector. `ack_vld_o` pulses in the cycle after the strobe.
- R6: A request sets its pending bit and writes its trigger bit: 1 for level (`req_level_i`=1), 0 for edge.
- R7: End-of-interrupt clears the largest in-service bit and changes nothing when none is set.
- R8: The spurious register is 9 bits. Bit 8 enables the block and bits 7:0 are the spurious vector. Reset sets it to 0x0FF (disabled), sets the task priority to 0, and clears all vector state and `irq_o`.
- R9: When a request and an acknowledge arrive in the same cycle, the acknowledge uses the state from before the request, and the request's pending bit is still set afterwards.
- R10: `irq_o` is registered: a state change at one clock edge shows up on `irq_o` at the following edge.
- R11: An acknowledge while disabled, or with nothing pending, returns spurious bits 7:0 and changes no vector state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Incoming request strobe |
| req_vec_i | input | 8 | Requested vector |
| req_level_i | input | 1 | 1 = level trigger, 0 = edge |
| tpr_we_i | input | 1 | Task-priority write strobe |
| tpr_wdata_i | input | 8 | Task-priority write data |
| svr_we_i | input | 1 | Spurious/enable register write strobe |
| svr_wdata_i | input | 9 | Spurious/enable write data (bit 8 enable) |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Interrupt request to processor |
| ack_vec_o | output | 8 | Vector returned for the last acknowledge |
| ack_vld_o | output | 1 | Pulse marking `ack_vec_o` as fresh |
| pend_o | output | 256 | Pending vector set |
| insvc_o | output | 256 | In-service vector set |
| trig_o | output | 256 | Trigger-mode vector set |
| ppr_o | output | 8 | Processor priority |

## Verification
The assertions assume that the strobes are single-cycle and sampled cleanly at the rising edge, and that reset is held for at least one edge before any request. They also assume that nothing sampled through `$past` can change in the reset cycle. The bench drives every input just after a falling edge and releases it one cycle later. It issues each acknowledge or end-of-interrupt on its own, except in the deliberate same-cycle request/acknowledge case. This keeps every strobe inside those assumptions.

// File: rtl/vipc_pkg.sv
package vipc_pkg;
  localparam int VEC_W  = 8;
  localparam int WORD_W = 32;
  localparam int NVEC   = 1 << VEC_W;
  localparam int NWORD  = NVEC / WORD_W;
  localparam int BIT_W  = $clog2(WORD_W);

  typedef logic [VEC_W-1:0] vec_t;

  // index of the most significant set bit of one word (0 if none)
  function automatic logic [BIT_W-1:0] word_msb(input logic [WORD_W-1:0] w);
    logic [BIT_W-1:0] r;
    r = '0;
    for (int i = 0; i < WORD_W; i++)
      if (w[i]) r = BIT_W'(i);
    return r;
  endfunction

  // priority class of a vector
  function automatic logic [3:0] vclass(input vec_t v);
    return v[VEC_W-1:VEC_W-4];
  endfunction

  // processor priority from task priority and top in-service vector
  function automatic vec_t calc_ppr(input vec_t tpr, input vec_t isr_top, input logic isr_any);
    logic [3:0] cls;
    cls = isr_any ? vclass(isr_top) : 4'd0;
    return (vclass(tpr) >= cls) ? tpr : {cls, 4'd0};
  endfunction

  // does the top pending vector beat the processor priority
  function automatic logic beats_ppr(input vec_t pend_top, input vec_t ppr);
    return (ppr == '0) || (vclass(pend_top) > vclass(ppr));
  endfunction
endpackage

// File: rtl/vipc_prio_enc.sv
module vipc_prio_enc
  import vipc_pkg::*;
#(
  parameter int NW = NWORD,
  parameter int WW = WORD_W
) (
  input  logic [NW*WW-1:0]          bits_i,
  output logic [$clog2(NW*WW)-1:0]  top_o,
  output logic                      any_o
);
  localparam int IW = $clog2(NW*WW);
  localparam int BW = $clog2(WW);

  logic [NW-1:0]         word_hit;
  logic [NW-1:0][BW-1:0] word_idx;

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign word_hit[w] = |bits_i[w*WW +: WW];
    assign word_idx[w] = BW'(word_msb(WORD_W'(bits_i[w*WW +: WW])));
  end

  always_comb begin
    top_o = '0;
    for (int w = 0; w < NW; w++)
      if (word_hit[w]) top_o = IW'(w * WW) + IW'(word_idx[w]);
  end

  assign any_o = |word_hit;
endmodule

// File: rtl/vipc_vec_bank.sv
module vipc_vec_bank
  import vipc_pkg::*;
#(
  parameter int NW = NWORD,
  parameter int WW = WORD_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_en_i,
  input  logic [$clog2(NW*WW)-1:0]  clr_idx_i,
  input  logic                      wr_en_i,
  input  logic [$clog2(NW*WW)-1:0]  wr_idx_i,
  input  logic                      wr_val_i,
  output logic [NW*WW-1:0]          bits_o
);
  localparam int IW = $clog2(NW*WW);
  localparam int BW = $clog2(WW);

  logic [NW-1:0][WW-1:0] q;

  // clear first, write second: a write to the same bit wins
  for (genvar w = 0; w < NW; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q[w] <= '0;
      end else begin
        if (clr_en_i && (clr_idx_i[IW-1:BW] == (IW-BW)'(w)))
          q[w][clr_idx_i[BW-1:0]] <= 1'b0;
        if (wr_en_i && (wr_idx_i[IW-1:BW] == (IW-BW)'(w)))
          q[w][wr_idx_i[BW-1:0]] <= wr_val_i;
      end
    end
  end

  assign bits_o = q;
endmodule

// File: rtl/vipc_top.sv
module vipc_top
  import vipc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic [7:0]       req_vec_i,
  input  logic             req_level_i,
  input  logic             tpr_we_i,
  input  logic [7:0]       tpr_wdata_i,
  input  logic             svr_we_i,
  input  logic [8:0]       svr_wdata_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             irq_o,
  output logic [7:0]       ack_vec_o,
  output logic             ack_vld_o,
  output logic [NVEC-1:0]  pend_o,
  output logic [NVEC-1:0]  insvc_o,
  output logic [NVEC-1:0]  trig_o,
  output logic [7:0]       ppr_o
);
  localparam logic [8:0] SVR_RST = 9'h0FF;

  vec_t       tpr_q;
  logic [8:0] svr_q;
  logic       irq_q;
  vec_t       ack_vec_q;
  logic       ack_vld_q;

  // named internal events
  vec_t pend_top, isr_top;
  logic pend_any, isr_any;
  logic sw_en;
  logic take;       // acknowledge consumes a pending bit
  logic spur_take;  // consumed but below task priority
  logic mark;       // consumed and moved to in-service
  logic retire;     // end-of-interrupt with something in service
  vec_t ppr;

  assign sw_en     = svr_q[8];
  assign take      = ack_i && sw_en && pend_any;
  assign spur_take = take && (tpr_q != '0) && (pend_top <= tpr_q);
  assign mark      = take && !spur_take;
  assign retire    = eoi_i && isr_any;

  vipc_prio_enc u_pend_enc (.bits_i(pend_o),  .top_o(pend_top), .any_o(pend_any));
  vipc_prio_enc u_isr_enc  (.bits_i(insvc_o), .top_o(isr_top),  .any_o(isr_any));

  vipc_vec_bank u_pend (
    .clk(clk), .rst_n(rst_n),
    .clr_en_i(take), .clr_idx_i(pend_top),
    .wr_en_i(req_valid_i), .wr_idx_i(req_vec_i), .wr_val_i(1'b1),
    .bits_o(pend_o));

  vipc_vec_bank u_isr (
    .clk(clk), .rst_n(rst_n),
    .clr_en_i(retire), .clr_idx_i(isr_top),
    .wr_en_i(mark), .wr_idx_i(pend_top), .wr_val_i(1'b1),
    .bits_o(insvc_o));

  vipc_vec_bank u_trig (
    .clk(clk), .rst_n(rst_n),
    .clr_en_i(1'b0), .clr_idx_i('0),
    .wr_en_i(req_valid_i), .wr_idx_i(req_vec_i), .wr_val_i(req_level_i),
    .bits_o(trig_o));

  assign ppr = calc_ppr(tpr_q, isr_top, isr_any);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpr_q     <= '0;
      svr_q     <= SVR_RST;
      irq_q     <= 1'b0;
      ack_vec_q <= '0;
      ack_vld_q <= 1'b0;
    end else begin
      if (tpr_we_i) tpr_q <= tpr_wdata_i;
      if (svr_we_i) svr_q <= svr_wdata_i;
      irq_q     <= sw_en && pend_any && beats_ppr(pend_top, ppr);
      ack_vld_q <= ack_i;
      if (ack_i) ack_vec_q <= mark ? pend_top : svr_q[7:0];
    end
  end

  assign irq_o     = irq_q;
  assign ack_vec_o = ack_vec_q;
  assign ack_vld_o = ack_vld_q;
  assign ppr_o     = ppr;

  // R3: request line implies enable and pending one cycle earlier
  assert_irq_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(sw_en && pend_any));

  // R6: request records pending and trigger mode
  assert_req_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> pend_o[$past(req_vec_i)] && (trig_o[$past(req_vec_i)] == $past(req_level_i)));

  // R5: accepted vector lands in service and is returned
  assert_mark_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mark |=> insvc_o[$past(pend_top)] && (ack_vec_o == $past(pend_top)) && ack_vld_o);

  // R5 / R11: non-accepted acknowledge returns spurious vector
  assert_spur_ret_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !mark) |=> (ack_vec_o == $past(svr_q[7:0])));

  // R7: end-of-interrupt with empty in-service set changes nothing
  assert_eoi_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !isr_any && !mark) |=> $stable(insvc_o));

  // R2: processor priority never below the task priority class
  assert_ppr_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ppr_o[7:4] >= tpr_q[7:4]) && ((ppr_o == tpr_q) || (ppr_o[3:0] == 4'd0)));
endmodule

// File: tb/sim_vipc_top.sv
module sim_vipc_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid_i = 0, req_level_i = 0, tpr_we_i = 0, svr_we_i = 0, ack_i = 0, eoi_i = 0;
  logic [7:0] req_vec_i = 0, tpr_wdata_i = 0;
  logic [8:0] svr_wdata_i = 0;
  logic irq_o, ack_vld_o;
  logic [7:0] ack_vec_o, ppr_o;
  logic [255:0] pend_o, insvc_o, trig_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vipc_top u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    req_valid_i = 0; tpr_we_i = 0; svr_we_i = 0; ack_i = 0; eoi_i = 0;
  endtask

  task automatic do_req(input logic [7:0] v, input logic lvl);
    req_valid_i = 1; req_vec_i = v; req_level_i = lvl; tick();
  endtask
  task automatic do_tpr(input logic [7:0] t); tpr_we_i = 1; tpr_wdata_i = t; tick(); endtask
  task automatic do_svr(input logic [8:0] s); svr_we_i = 1; svr_wdata_i = s; tick(); endtask
  task automatic do_ack(); ack_i = 1; tick(); endtask
  task automatic do_eoi(); eoi_i = 1; tick(); endtask

  // {vector, level, tpr, expected ack vector, expect in-service}
  localparam int NT = 7;
  localparam logic [25:0] TBL [NT] = '{
    {8'h45, 1'b0, 8'h00, 8'h45, 1'b1},
    {8'h30, 1'b1, 8'h40, 8'hF7, 1'b0},
    {8'h41, 1'b0, 8'h40, 8'h41, 1'b1},
    {8'h40, 1'b0, 8'h40, 8'hF7, 1'b0},
    {8'hFF, 1'b1, 8'hF0, 8'hFF, 1'b1},
    {8'h10, 1'b0, 8'h00, 8'h10, 1'b1},
    {8'h00, 1'b1, 8'h00, 8'h00, 1'b1}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    chk("R8 pend reset", 32'(pend_o != 0), 0);
    chk("R8 insvc reset", 32'(insvc_o != 0), 0);
    chk("R8 ppr reset", 32'(ppr_o), 0);
    chk("R8 irq reset", 32'(irq_o), 0);

    do_svr(9'h1F7);
    for (int i = 0; i < NT; i++) begin
      logic [7:0] v, t, e; logic l, m;
      {v, l, t, e, m} = TBL[i];
      do_tpr(t);
      do_req(v, l);
      chk("R6 pending set", 32'(pend_o[v]), 1);
      chk("R6 trigger bit", 32'(trig_o[v]), 32'(l));
      do_ack();
      chk("R5 ack valid", 32'(ack_vld_o), 1);
      chk("R5 ack vector", 32'(ack_vec_o), 32'(e));
      chk("R5 in-service mark", 32'(insvc_o[v]), 32'(m));
      chk("R5 pending cleared", 32'(pend_o[v]), 0);
      if (m) begin
        do_eoi();
        chk("R7 retired", 32'(insvc_o != 0), 0);
      end
    end

    // disabled block: R3 / R11
    do_svr(9'h0FF);
    do_req(8'h80, 0);
    tick(); tick();
    chk("R3 irq while disabled", 32'(irq_o), 0);
    do_ack();
    chk("R11 disabled ack vector", 32'(ack_vec_o), 32'h0FF);
    chk("R11 pending kept", 32'(pend_o[8'h80]), 1);
    do_svr(9'h035);
    do_ack();
    chk("R8 spurious low byte", 32'(ack_vec_o), 32'h35);
    chk("R11 no insvc change", 32'(insvc_o != 0), 0);

    // R10 irq one edge after enable
    do_svr(9'h1F7);
    chk("R10 irq not yet", 32'(irq_o), 0);
    tick();
    chk("R10 irq registered", 32'(irq_o), 1);

    // R1 / R2 / R4
    do_req(8'h20, 0);
    do_req(8'h81, 0);
    do_ack();
    chk("R1 highest taken", 32'(ack_vec_o), 32'h81);
    chk("R2 ppr from insvc", 32'(ppr_o), 32'h80);
    tick();
    chk("R4 same class suppressed", 32'(irq_o), 0);
    do_tpr(8'h90);
    chk("R2 ppr from tpr", 32'(ppr_o), 32'h90);
    do_tpr(8'h50);
    chk("R2 insvc class wins", 32'(ppr_o), 32'h80);
    do_req(8'h95, 0);
    tick();
    chk("R4 higher class raises irq", 32'(irq_o), 1);
    do_ack();
    chk("R1 new top taken", 32'(ack_vec_o), 32'h95);
    do_eoi();
    chk("R7 top retired", 32'(insvc_o[8'h95]), 0);
    chk("R7 lower kept", 32'(insvc_o[8'h81]), 1);
    do_eoi();
    chk("R7 second retired", 32'(insvc_o != 0), 0);
    do_eoi();
    chk("R7 empty eoi no change", 32'(insvc_o != 0), 0);
    chk("R7 pending untouched", 32'(pend_o[8'h80] && pend_o[8'h20]), 1);

    // R9 request and acknowledge together
    do_tpr(8'h00);
    req_valid_i = 1; req_vec_i = 8'h80; req_level_i = 0; ack_i = 1; tick();
    chk("R9 ack on old state", 32'(ack_vec_o), 32'h80);
    chk("R9 new pending kept", 32'(pend_o[8'h80]), 1);
    do_eoi();
    do_ack();
    chk("R9 second take", 32'(ack_vec_o), 32'h80);
    do_eoi();
    do_ack();
    chk("R1 lowest last", 32'(ack_vec_o), 32'h20);
    do_eoi();
    chk("R5 all drained", 32'(pend_o != 0), 0);

    // R6 trigger overwritten
    do_req(8'h33, 1);
    chk("R6 level trig", 32'(trig_o[8'h33]), 1);
    do_req(8'h33, 0);
    chk("R6 edge clears trig", 32'(trig_o[8'h33]), 0);

    finish_run();
  end
endmodule